// File: doc/BRIEF.md
# Emergency Brake Lamp Flasher

This block turns a steady hard-braking flag into a flashing brake lamp. A relay on the lamp circuit switches the lamp off while the block's output is high. The block gates a free-running square wave of about 10 Hz onto that output whenever hard braking is in progress, so the lamp blinks and not just glows. Following drivers see the difference between a gentle stop and an emergency stop.

A short burst of hard braking still leaves the car behind closing fast. For that reason the flashing outlives the braking flag by a hold window of one second. Every clock edge at which the braking flag is present reloads that window to its full length, so repeated or sustained braking keeps extending it. When the window runs out, the output is forced low and the lamp goes back to its normal brake-switch behaviour.

The clock rate, flash rate and hold length are parameters. The defaults describe a 10 MHz clock, 10 Hz flashing and a 1000 ms hold. From these the block derives a half-period of 500,000 cycles and a hold of 10,000,000 cycles. All inputs are plain control levels, so the block has no streaming interface and no back-pressure.

Top module: `brake_flash_pulser`

## Requirements
- R1: An edge with `rst` high clears the flash phase counter and the hold counter. At that edge the square wave is set low, and `lamp_blank` reads 0 after it.
- R2: The square wave runs freely whatever `brake_n` does. It toggles once every HALF_CYC = CLK_HZ/(2*FLASH_HZ) edges, and its first rise comes HALF_CYC edges after reset is released.
- R3: Each edge at which `brake_n` is sampled low (low means hard braking) loads the hold counter with HOLD_CYC = (CLK_HZ/1000)*HOLD_MS.
- R4: While the hold counter is non-zero, `lamp_blank` equals the square wave level (1 means the lamp is off).
- R5: The hold counter falls by one at each edge with `brake_n` high. After HOLD_CYC such edges since the last low sample, `lamp_blank` is 0 and stays 0 until `brake_n` goes low again.
- R6: A low `brake_n` in the middle of a running hold window restarts the full HOLD_CYC window. It does not move the flash phase.
- R7: With the hold counter at zero, a high `brake_n` has no effect: `lamp_blank` stays 0 through every phase of the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| brake_n | input | 1 | Hard-braking flag, active low |
| lamp_blank | output | 1 | Relay drive; high switches the lamp off |

## Verification
The hardest case to reach from the ports is a retrigger that lands deep inside a running hold window. It must happen while the square wave is in a phase that would show a premature switch-off. The bench drives a stretch of braking and releases it for more than half of the hold. It then pulses `brake_n` low for a few cycles and watches that the flashing lasts a full new window measured from the last low sample. A reset inside a live window, followed by idle cycles that span several wave half-periods, confirms that the hold is truly cleared.

// File: rtl/brake_flash_pkg.sv
package brake_flash_pkg;

  // Edges per half period of the flash square wave.
  function automatic longint unsigned half_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned flash_hz);
    return clk_hz / (2 * flash_hz);
  endfunction

  // Edges in the hold window after the last braking sample.
  function automatic longint unsigned hold_cycles(input longint unsigned clk_hz,
                                                  input longint unsigned hold_ms);
    return (clk_hz / 1000) * hold_ms;
  endfunction

endpackage

// File: rtl/flash_divider.sv
module flash_divider #(
  parameter longint unsigned HALF_CYC = 500_000
) (
  input  logic clk,
  input  logic rst,
  output logic wave
);
  localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(HALF_CYC - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      wave  <= 1'b0;
    end else if (phase == LAST) begin
      phase <= '0;
      wave  <= ~wave;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // R2
  wave_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wave) |-> ($past(phase) == LAST));

  // R1
  phase_clear_chk: assert property (@(posedge clk)
    rst |=> (phase == '0 && !wave));

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter longint unsigned HOLD_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic brake_n,
  output logic active
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_CYC);

  logic [HW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (!brake_n)
      remain <= FULL;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    !brake_n |=> (remain == FULL));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (brake_n && active) |=> (remain == $past(remain) - 1'b1));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    remain <= FULL);

endmodule

// File: rtl/brake_flash_pulser.sv
module brake_flash_pulser
  import brake_flash_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 10_000_000,
  parameter longint unsigned FLASH_HZ = 10,
  parameter longint unsigned HOLD_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic brake_n,
  output logic lamp_blank
);
  localparam longint unsigned HALF_CYC = half_cycles(CLK_HZ, FLASH_HZ);
  localparam longint unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_MS);

  logic wave;
  logic hold_on;

  flash_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .wave (wave)
  );

  hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .brake_n (brake_n),
    .active  (hold_on)
  );

  assign lamp_blank = wave & hold_on;

  // R4
  blank_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lamp_blank) |-> ($rose(wave) || $rose(hold_on)));

  // R7
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!hold_on) && brake_n && $past(brake_n)) |-> !lamp_blank);

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> !lamp_blank);

endmodule

// File: tb/tb_brake_flash_pulser.sv
module tb_brake_flash_pulser;
  localparam longint unsigned CLK_HZ   = 1000;
  localparam longint unsigned FLASH_HZ = 50;
  localparam longint unsigned HOLD_MS  = 100;
  localparam int HALF = 10;   // 1000/(2*50)
  localparam int HOLD = 100;  // (1000/1000)*100

  // entry: {brake_n, cycles[15:0], requirement number[7:0]}
  localparam int NSEG = 8;
  localparam logic [24:0] SEG [NSEG] = '{
    {1'b1, 16'd30,  8'd7},  // R7 idle after reset: dark
    {1'b0, 16'd45,  8'd2},  // R2 wave phase while braking
    {1'b1, 16'd150, 8'd5},  // R5 hold then dark
    {1'b0, 16'd5,   8'd3},  // R3 short brake reloads
    {1'b1, 16'd60,  8'd4},  // R4 mid-window flashing
    {1'b0, 16'd3,   8'd6},  // R6 retrigger inside window
    {1'b1, 16'd120, 8'd6},  // R6 full window restarts
    {1'b1, 16'd25,  8'd7}   // R7 still dark
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic brake_n = 1'b1;
  logic lamp_blank;

  int checks = 0;
  int fails  = 0;
  int ph = 0;
  int hd = 0;
  logic wv = 1'b0;

  always #10 clk = ~clk;

  brake_flash_pulser #(.CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ), .HOLD_MS(HOLD_MS)) dut (
    .clk(clk), .rst(rst), .brake_n(brake_n), .lamp_blank(lamp_blank)
  );

  task automatic check(input logic exp, input int req);
    checks++;
    if (lamp_blank !== exp) begin
      fails++;
      $display("FAIL R%0d: lamp_blank=%b expected %b at %0t", req, lamp_blank, exp, $time);
    end
  endtask

  // One edge: drive, update the reference from the requirements, compare.
  task automatic tick(input logic b, input logic r, input int req);
    brake_n = b;
    rst = r;
    @(posedge clk);
    if (r) begin
      ph = 0; wv = 1'b0; hd = 0;          // R1
    end else begin
      if (ph == HALF - 1) begin ph = 0; wv = ~wv; end else ph++;  // R2
      if (!b) hd = HOLD;                   // R3
      else if (hd != 0) hd--;              // R5
    end
    #2;
    check(wv & (hd != 0), req);            // R4
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(1'b0, 1'b1, 1);
    tick(1'b0, 1'b1, 1);
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < int'(SEG[s][23:8]); c++)
        tick(SEG[s][24], 1'b0, int'(SEG[s][7:0]));
    end

    // R1 reset inside a live window clears the hold
    for (int c = 0; c < 25; c++) tick(1'b0, 1'b0, 4);
    tick(1'b1, 1'b1, 1);
    for (int c = 0; c < 4 * HALF; c++) tick(1'b1, 1'b0, 1);

    // R5 exact window edge: last low sample then HOLD high edges
    tick(1'b0, 1'b0, 3);
    for (int c = 0; c < HOLD + 2 * HALF; c++) tick(1'b1, 1'b0, 5);

    // R6 repeated one-cycle pulses keep the window alive
    for (int k = 0; k < 5; k++) begin
      tick(1'b0, 1'b0, 6);
      for (int c = 0; c < HOLD - 10; c++) tick(1'b1, 1'b0, 6);
    end
    for (int c = 0; c < 30; c++) tick(1'b1, 1'b0, 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule